// File: doc/BRIEF.md
# Exception Context Save/Restore Unit

This block keeps the return state that a processor needs when it leaves its current context for an interrupt, an exception, a supervisor call or debug mode. Every target context owns one pair of registers: a saved status word and a saved re-entry address. When the core accepts a mode change, the block records the interrupted context's status word and re-entry address in the pair of the context being entered. When the matching return command arrives, the block reads that pair back. It drives the restored status and a change-of-flow address for exactly one cycle.

There are seven ordinary contexts: supervisor, four interrupt levels, exception, and non-maskable interrupt. Debug has a pair of its own. The block also holds a cause register, which records a compressed vector offset for each qualifying exception so that handler software can find out why it was entered. Instruction decode, vector-base arithmetic and interrupt arbitration are done elsewhere.

Top module: `exc_ctx_unit`

## Requirements
- R1: A synchronous active-high reset clears the cause register and `flow_valid_o`, and it marks every saved pair as empty. A return from a context that has not been entered since reset yields address 0 and status 0.
- R2: An accept with context code c stores `cur_status_i` and `reentry_addr_i` into the pair owned by c. The context codes are: 0 = supervisor, 1..4 = interrupt levels 0..3, 5 = exception, 6 = non-maskable interrupt.
- R3: A return pulse with code c, sampled at clock edge k, raises `flow_valid_o` after edge k for one cycle per return. During that cycle `flow_addr_o` and `rest_status_o` carry the pair saved for c.
- R4: Code 7 selects the debug pair. Entering debug saves the status and the program counter there, and a debug return restores both. This pair is separate from the other seven contexts.
- R5: On a qualifying accept (`exc_kind_i` = 0), `cause_o` loads bits [8:2] of `vec_offset_i`, which is the 9-bit offset shifted right by two. Offset bits above 8 are ignored. An offset of 0x50 gives 0x14.
- R6: When `exc_kind_i` is 1 (system call), 2 (breakpoint) or 3 (debugger stop request), `cause_o` keeps its value. The context pair is still saved.
- R7: Interrupt accepts (codes 1..4) load the cause from the supplied autovector offset by the same rule. A value equal to one produced by an exception is accepted without any check.
- R8: When an accept and a return occur in the same cycle, the accept is performed and the return is dropped. `flow_valid_o` stays low in the following cycle.
- R9: `flow_addr_o` and `rest_status_o` change only in the cycle that follows a performed return. Otherwise they hold their value, even while accepts rewrite the pairs.
- R10: A saved pair stays in place until the next accept into the same context overwrites it. Back-to-back returns each produce their own valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept_i | input | 1 | Mode change accepted this cycle |
| accept_ctx_i | input | 3 | Context being entered |
| exc_kind_i | input | 2 | 0 qualifying, 1 system call, 2 breakpoint, 3 debugger stop |
| cur_status_i | input | SR_W | Status word of the interrupted context |
| reentry_addr_i | input | ADDR_W | Re-entry address or program counter |
| vec_offset_i | input | OFS_W | Vector offset of the exception or autovector |
| ret_i | input | 1 | Return command this cycle |
| ret_ctx_i | input | 3 | Context being returned from |
| flow_valid_o | output | 1 | Change of flow, one cycle per return |
| flow_addr_o | output | ADDR_W | Return address |
| rest_status_o | output | SR_W | Restored status word |
| cause_o | output | VEC_W-2 | Cause register |

## Verification
The checker evaluates four rules on every cycle:
- `flow_valid_o` rises exactly one cycle after a return that no accept preempted.
- The cause register changes only on a qualifying accept.
- When the cause register does load, it takes the shifted offset.
- The flow outputs hold still when no return was performed.

Whether a given return address belongs to the right context can only be shown by the bench's scenarios. The same holds for the independence of the debug pair and the empty state after reset. For these, a scoreboard compares each change of flow against a context model.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam int CTX_CODE_W = 3;
  localparam int NUM_CTX    = 1 << CTX_CODE_W;

  typedef enum logic [CTX_CODE_W-1:0] {
    CTX_SUP  = 3'd0,
    CTX_INT0 = 3'd1,
    CTX_INT1 = 3'd2,
    CTX_INT2 = 3'd3,
    CTX_INT3 = 3'd4,
    CTX_EXC  = 3'd5,
    CTX_NMI  = 3'd6,
    CTX_DBG  = 3'd7
  } ctx_code_e;

  typedef enum logic [1:0] {
    KIND_NORMAL  = 2'd0,
    KIND_SYSCALL = 2'd1,
    KIND_BRKPT   = 2'd2,
    KIND_DBGSTOP = 2'd3
  } exc_kind_e;
endpackage

// File: rtl/ecu_ctrl.sv
module ecu_ctrl
  import ecu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  accept_i,
  input  logic [1:0]            exc_kind_i,
  input  logic                  ret_i,
  output logic                  save_we,
  output logic                  load_re,
  output logic                  cause_en,
  output logic                  flow_valid_q
);
  // accept wins over return in the same cycle
  always_comb begin
    save_we  = accept_i;
    load_re  = ret_i & ~accept_i;
    cause_en = accept_i & (exc_kind_e'(exc_kind_i) == KIND_NORMAL);
  end

  always_ff @(posedge clk) begin
    if (rst) flow_valid_q <= 1'b0;
    else     flow_valid_q <= load_re;
  end
endmodule

// File: rtl/ecu_save_bank.sv
module ecu_save_bank #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata_q
);
  // storage without reset so it maps to RAM; emptiness tracked by flags
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  filled;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     filled        <= '0;
    else if (we) filled[waddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= filled[raddr] ? mem[raddr] : '0;
  end
endmodule

// File: rtl/ecu_cause_reg.sv
module ecu_cause_reg #(
  parameter int OFS_W = 16,
  parameter int VEC_W = 9,
  localparam int CAUSE_W = VEC_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [OFS_W-1:0]   offset,
  output logic [CAUSE_W-1:0] cause_q
);
  always_ff @(posedge clk) begin
    if (rst)     cause_q <= '0;
    else if (en) cause_q <= offset[VEC_W-1:2];
  end
endmodule

// File: rtl/exc_ctx_unit.sv
module exc_ctx_unit
  import ecu_pkg::*;
#(
  parameter int SR_W   = 32,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int VEC_W  = 9,
  localparam int CAUSE_W = VEC_W - 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  accept_i,
  input  logic [CTX_CODE_W-1:0] accept_ctx_i,
  input  logic [1:0]            exc_kind_i,
  input  logic [SR_W-1:0]       cur_status_i,
  input  logic [ADDR_W-1:0]     reentry_addr_i,
  input  logic [OFS_W-1:0]      vec_offset_i,
  input  logic                  ret_i,
  input  logic [CTX_CODE_W-1:0] ret_ctx_i,
  output logic                  flow_valid_o,
  output logic [ADDR_W-1:0]     flow_addr_o,
  output logic [SR_W-1:0]       rest_status_o,
  output logic [CAUSE_W-1:0]    cause_o
);
  logic save_we, load_re, cause_en;

  ecu_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .accept_i     (accept_i),
    .exc_kind_i   (exc_kind_i),
    .ret_i        (ret_i),
    .save_we      (save_we),
    .load_re      (load_re),
    .cause_en     (cause_en),
    .flow_valid_q (flow_valid_o)
  );

  ecu_save_bank #(.DEPTH(NUM_CTX), .DATA_W(SR_W)) u_status_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (save_we),
    .waddr   (accept_ctx_i),
    .wdata   (cur_status_i),
    .re      (load_re),
    .raddr   (ret_ctx_i),
    .rdata_q (rest_status_o)
  );

  ecu_save_bank #(.DEPTH(NUM_CTX), .DATA_W(ADDR_W)) u_addr_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (save_we),
    .waddr   (accept_ctx_i),
    .wdata   (reentry_addr_i),
    .re      (load_re),
    .raddr   (ret_ctx_i),
    .rdata_q (flow_addr_o)
  );

  ecu_cause_reg #(.OFS_W(OFS_W), .VEC_W(VEC_W)) u_cause (
    .clk     (clk),
    .rst     (rst),
    .en      (cause_en),
    .offset  (vec_offset_i),
    .cause_q (cause_o)
  );
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker #(
  parameter int SR_W   = 32,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int VEC_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              accept_i,
  input logic [1:0]        exc_kind_i,
  input logic [OFS_W-1:0]  vec_offset_i,
  input logic              ret_i,
  input logic              flow_valid_o,
  input logic [ADDR_W-1:0] flow_addr_o,
  input logic [SR_W-1:0]   rest_status_o,
  input logic [VEC_W-3:0]  cause_o
);
  AST_FLOW_PULSE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flow_valid_o == $past(ret_i && !accept_i)));  // R3
  AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (accept_i && exc_kind_i == 2'd0) |=> (cause_o == $past(vec_offset_i[VEC_W-1:2])));  // R5
  AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(accept_i && exc_kind_i == 2'd0) |=> $stable(cause_o));  // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(ret_i && !accept_i) |=> ($stable(flow_addr_o) && $stable(rest_status_o)));  // R9
  AST_ACCEPT_WINS: assert property (@(posedge clk) disable iff (rst)
    (accept_i && ret_i) |=> !flow_valid_o);  // R8
endmodule

bind exc_ctx_unit ecu_checker #(
  .SR_W(SR_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .VEC_W(VEC_W)
) u_ecu_checker (
  .clk           (clk),
  .rst           (rst),
  .accept_i      (accept_i),
  .exc_kind_i    (exc_kind_i),
  .vec_offset_i  (vec_offset_i),
  .ret_i         (ret_i),
  .flow_valid_o  (flow_valid_o),
  .flow_addr_o   (flow_addr_o),
  .rest_status_o (rest_status_o),
  .cause_o       (cause_o)
);

// File: tb/tb_exc_ctx_unit.sv
module tb_exc_ctx_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accept_i = 1'b0;
  logic [2:0]  accept_ctx_i = '0;
  logic [1:0]  exc_kind_i = '0;
  logic [31:0] cur_status_i = '0;
  logic [31:0] reentry_addr_i = '0;
  logic [15:0] vec_offset_i = '0;
  logic        ret_i = 1'b0;
  logic [2:0]  ret_ctx_i = '0;
  logic        flow_valid_o;
  logic [31:0] flow_addr_o;
  logic [31:0] rest_status_o;
  logic [6:0]  cause_o;

  always #5 clk = ~clk;

  exc_ctx_unit dut (.*);

  int checks = 0;
  int failures = 0;
  logic [31:0] m_sr [8];
  logic [31:0] m_ad [8];
  logic [6:0]  m_cause = '0;
  logic [63:0] expq [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare every change of flow against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && flow_valid_o) begin
        if (expq.size() == 0) chk(1'b0, "R3 unexpected flow", {flow_addr_o, rest_status_o}, 64'h0);
        else begin
          logic [63:0] e;
          e = expq.pop_front();
          chk({flow_addr_o, rest_status_o} == e, "R3 restored pair", {flow_addr_o, rest_status_o}, e);
        end
      end
    end
  end

  task automatic do_accept(input logic [2:0] c, input logic [31:0] sr, input logic [31:0] ad,
                           input logic [15:0] ofs, input logic [1:0] k, input string req);
    @(negedge clk);
    accept_i = 1'b1; accept_ctx_i = c; cur_status_i = sr; reentry_addr_i = ad;
    vec_offset_i = ofs; exc_kind_i = k;
    @(negedge clk);
    accept_i = 1'b0;
    m_sr[c] = sr; m_ad[c] = ad;
    if (k == 2'd0) m_cause = ofs[8:2];
    chk(cause_o == m_cause, req, {57'b0, cause_o}, {57'b0, m_cause});
  endtask

  task automatic do_return(input logic [2:0] c);
    @(negedge clk);
    ret_i = 1'b1; ret_ctx_i = c;
    expq.push_back({m_ad[c], m_sr[c]});
    @(negedge clk);
    ret_i = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_sr[i] = '0; m_ad[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cause_o == 7'h0, "R1 cause after reset", {57'b0, cause_o}, 64'h0);
    chk(flow_valid_o == 1'b0, "R1 flow valid after reset", {63'b0, flow_valid_o}, 64'h0);
    do_return(3'd3);  // R1 empty pair reads as zero
    do_return(3'd7);

    // R2 R7 fill every context with distinct values
    for (int c = 0; c < 7; c++)
      do_accept(3'(c), 32'h5A00_0000 + 32'(c), 32'h8000_1000 + 32'(c * 16), 16'(32 * c + 4), 2'd0, "R7 cause per accept");
    // R4 debug pair
    do_accept(3'd7, 32'hDEB0_0001, 32'hD000_0100, 16'h0044, 2'd3, "R6 debug stop keeps cause");
    for (int c = 0; c < 8; c++) do_return(3'(c));  // R2 R3 R4

    // R5 known offsets
    do_accept(3'd5, 32'h1, 32'h2, 16'h0050, 2'd0, "R5 offset 0x50");
    chk(cause_o == 7'h14, "R5 value 0x14", {57'b0, cause_o}, 64'h14);
    do_accept(3'd5, 32'h3, 32'h4, 16'hFE1C, 2'd0, "R5 high bits ignored");
    // R6 skipped kinds
    do_accept(3'd0, 32'h11, 32'h22, 16'h01FC, 2'd1, "R6 syscall");
    do_accept(3'd5, 32'h33, 32'h44, 16'h0100, 2'd2, "R6 breakpoint");
    do_accept(3'd7, 32'h55, 32'h66, 16'h0180, 2'd3, "R6 dbg stop");
    do_return(3'd0);  // R6 pair still saved
    // R7 interrupt cause colliding with an exception value
    do_accept(3'd2, 32'h77, 32'h88, 16'h0050, 2'd0, "R7 autovector collision");

    // R8 accept and return together
    @(negedge clk);
    accept_i = 1'b1; accept_ctx_i = 3'd4; cur_status_i = 32'hAAAA_0004; reentry_addr_i = 32'hBBBB_0004;
    vec_offset_i = 16'h0010; exc_kind_i = 2'd0; ret_i = 1'b1; ret_ctx_i = 3'd4;
    @(negedge clk);
    accept_i = 1'b0; ret_i = 1'b0;
    m_sr[4] = 32'hAAAA_0004; m_ad[4] = 32'hBBBB_0004; m_cause = 7'h04;
    chk(flow_valid_o == 1'b0, "R8 return dropped", {63'b0, flow_valid_o}, 64'h0);
    do_return(3'd4);  // R8 accept took effect

    // R9 hold while accepts rewrite the pair
    begin
      logic [63:0] held;
      @(negedge clk);
      held = {flow_addr_o, rest_status_o};
      do_accept(3'd4, 32'hCCCC_0000, 32'hEEEE_0000, 16'h0020, 2'd0, "R5 cause during hold");
      repeat (2) @(negedge clk);
      chk({flow_addr_o, rest_status_o} == held, "R9 outputs held", {flow_addr_o, rest_status_o}, held);
      chk(flow_valid_o == 1'b0, "R9 no flow without return", {63'b0, flow_valid_o}, 64'h0);
    end

    // R10 overwrite and back-to-back returns
    do_accept(3'd0, 32'h0F0F_0F0F, 32'h1234_5678, 16'h0000, 2'd1, "R10 overwrite cause kept");
    @(negedge clk);
    ret_i = 1'b1; ret_ctx_i = 3'd0; expq.push_back({m_ad[0], m_sr[0]});
    @(negedge clk);
    ret_ctx_i = 3'd7; expq.push_back({m_ad[7], m_sr[7]});
    @(negedge clk);
    ret_i = 1'b0;
    chk(flow_valid_o == 1'b1, "R10 second back-to-back valid", {63'b0, flow_valid_o}, 64'h1);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R3 all returns observed", 64'(expq.size()), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule